// File: doc/BRIEF.md
# Tiled-Window Parallel Convolution Engine

The engine convolves a square image of unsigned 8-bit pixels, held in an on-chip register array, with a small square kernel of signed 8-bit weights at a stride chosen when the run starts. It does not step a single window across the image. On each pass it lays a grid of kernel-sized windows over the whole image and evaluates every window in that grid at once. The grid is then moved sideways for the next passes, and after that downwards. The number of passes depends only on the kernel size and the stride, never on the image size.

Each pass has three stages. The first cycle computes, for every window, the sum of the pixels weighted by the positive weights. The second cycle computes the sum of the pixels weighted by the magnitudes of the negative weights and subtracts it. The signed window results are then streamed out one per cycle, each tagged with the row and column of its window origin. Software loads the pixels and weights through two write ports, pulses start together with a stride, and collects the result stream until done pulses. A stride that the image cannot hold is refused with an error pulse.

Top module: `fsca_conv_engine`

## Requirements
- R1: After reset, busy, done, err and res_valid are all low.
- R2: A start with stride 0, or with IMG_N < KER_N + stride, makes err high for exactly one cycle. No pass runs, and neither res_valid nor done is asserted after it.
- R3: Each emitted res_value equals the sum over i,j in 0..KER_N-1 of pixel(row+i, col+j) times weight(i,j). Pixels are 8-bit unsigned, weights are 8-bit two's complement, and (res_row, res_col) is the window origin.
- R4: Pass offsets (v, h) each take the values 0, s, 2s, … that are below KER_N. h changes fastest and v slowest. Within a pass the window origins are (v + a·(KER_N+s−1), h + b·(KER_N+s−1)). Only origins with both coordinates ≤ IMG_N−KER_N are emitted, in row-major order (a outer, b inner).
- R5: A run emits exactly the number of results that the R4 grid walk gives. For the default 6×6 image and 3×3 kernel this is 16 at stride 1, 4 at stride 2 and 1 at stride 3.
- R6: Results are exact at full scale: all pixels 255 with all weights −128 gives −293760, and with all weights 127 gives 291465.
- R7: busy is high from the cycle after an accepted start until the run completes. done is high for exactly one cycle, after the last result, and never together with res_valid.
- R8: A start pulse while busy is ignored. The run in progress keeps its stride, and its result stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_we | input | 1 | Pixel write strobe |
| pix_row | input | CRD_W | Pixel row address |
| pix_col | input | CRD_W | Pixel column address |
| pix_data | input | 8 | Unsigned pixel value |
| ker_we | input | 1 | Weight write strobe |
| ker_row | input | KCRD_W | Weight row address |
| ker_col | input | KCRD_W | Weight column address |
| ker_data | input | 8 | Signed weight value |
| start | input | 1 | Start request, one-cycle pulse |
| stride | input | STR_W | Stride sampled with start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle run-complete pulse |
| err | output | 1 | One-cycle illegal-stride pulse |
| res_valid | output | 1 | Result strobe |
| res_row | output | CRD_W | Origin row of the result window |
| res_col | output | CRD_W | Origin column of the result window |
| res_value | output | RES_W | Signed window sum |

## Verification
The assertions assume three things about the inputs: start is a single-cycle pulse, pixel and weight writes do not happen during a run, and load addresses stay inside the image and the kernel. The stimulus writes the whole image and kernel while the engine is idle and drives start for exactly one cycle. The only exception is one deliberate second pulse during a run, which checks that it is ignored. Random images and kernels from a fixed seed are mixed with the full-scale extremes and with every legal and illegal stride for the default size.

// File: rtl/fsca_pkg.sv
package fsca_pkg;
  localparam int PIX_W = 8;
  localparam int WGT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POS,
    ST_NEG,
    ST_EMIT,
    ST_FIN
  } fsca_state_e;
endpackage

// File: rtl/fsca_window_mac.sv
module fsca_window_mac #(
  parameter int IMG_N = 6,
  parameter int KER_N = 3,
  parameter int POS_W = 20
) (
  input  logic [IMG_N*IMG_N*fsca_pkg::PIX_W-1:0] img,
  input  logic [KER_N*KER_N*fsca_pkg::WGT_W-1:0] ker,
  input  int                                     orow,
  input  int                                     ocol,
  input  logic                                   ok,
  output logic [POS_W-1:0]                       pos_sum,
  output logic [POS_W-1:0]                       neg_sum
);
  localparam int PW = fsca_pkg::PIX_W;
  localparam int WW = fsca_pkg::WGT_W;

  always_comb begin
    int r0;
    int c0;
    logic [PW-1:0]    pix;
    logic [WW-1:0]    kv;
    logic [WW-1:0]    mag;
    logic [PW+WW-1:0] prod;
    pos_sum = '0;
    neg_sum = '0;
    r0 = ok ? orow : 0;
    c0 = ok ? ocol : 0;
    for (int i = 0; i < KER_N; i++) begin
      for (int j = 0; j < KER_N; j++) begin
        pix  = img[((r0 + i) * IMG_N + (c0 + j)) * PW +: PW];
        kv   = ker[(i * KER_N + j) * WW +: WW];
        mag  = kv[WW-1] ? (~kv + {{(WW-1){1'b0}}, 1'b1}) : kv;
        prod = {{WW{1'b0}}, pix} * {{PW{1'b0}}, mag};
        if (kv[WW-1]) neg_sum = neg_sum + POS_W'(prod);
        else          pos_sum = pos_sum + POS_W'(prod);
      end
    end
  end
endmodule

// File: rtl/fsca_pass_seq.sv
module fsca_pass_seq
  import fsca_pkg::*;
#(
  parameter int IMG_N = 6,
  parameter int KER_N = 3,
  parameter int STR_W = 3,
  parameter int SLOTS = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [STR_W-1:0] stride,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             pos_phase,
  output logic             neg_phase,
  output logic             emit_en,
  output logic [IDX_W-1:0] emit_idx,
  output logic [STR_W-1:0] voff,
  output logic [STR_W-1:0] hoff,
  output logic [STR_W-1:0] stride_q
);
  fsca_state_e      state_q, state_d;
  logic [STR_W-1:0] stride_d, voff_q, voff_d, hoff_q, hoff_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d, err_q, err_d;
  logic             legal;
  int               h_next, v_next;

  always_comb begin
    legal  = (stride != '0) && ((int'(stride) + KER_N) <= IMG_N);
    h_next = int'(hoff_q) + int'(stride_q);
    v_next = int'(voff_q) + int'(stride_q);
  end

  always_comb begin
    state_d  = state_q;
    stride_d = stride_q;
    voff_d   = voff_q;
    hoff_d   = hoff_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        if (legal) begin
          state_d  = ST_POS;
          stride_d = stride;
          voff_d   = '0;
          hoff_d   = '0;
        end else begin
          err_d = 1'b1;
        end
      end
      ST_POS: state_d = ST_NEG;
      ST_NEG: begin
        state_d = ST_EMIT;
        idx_d   = '0;
      end
      ST_EMIT: begin
        if (idx_q == IDX_W'(SLOTS - 1)) begin
          if (h_next < KER_N) begin
            hoff_d  = STR_W'(h_next);
            state_d = ST_POS;
          end else if (v_next < KER_N) begin
            voff_d  = STR_W'(v_next);
            hoff_d  = '0;
            state_d = ST_POS;
          end else begin
            state_d = ST_FIN;
          end
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_FIN: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      stride_q <= '0;
      voff_q   <= '0;
      hoff_q   <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) stride_q <= stride_d;
      voff_q  <= voff_d;
      hoff_q  <= hoff_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign pos_phase = (state_q == ST_POS);
  assign neg_phase = (state_q == ST_NEG);
  assign emit_en   = (state_q == ST_EMIT);
  assign emit_idx  = idx_q;
  assign voff      = voff_q;
  assign hoff      = hoff_q;

  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy);
  // R4
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(voff_q) < KER_N) && (int'(hoff_q) < KER_N));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8
  stride_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(stride_q));
endmodule

// File: rtl/fsca_conv_engine.sv
module fsca_conv_engine
  import fsca_pkg::*;
#(
  parameter int IMG_N = 6,
  parameter int KER_N = 3,
  localparam int CRD_W  = ($clog2(IMG_N) > 0) ? $clog2(IMG_N) : 1,
  localparam int KCRD_W = ($clog2(KER_N) > 0) ? $clog2(KER_N) : 1,
  localparam int STR_W  = $clog2(IMG_N + 1),
  localparam int POS_W  = PIX_W + WGT_W + $clog2(KER_N * KER_N + 1),
  localparam int RES_W  = POS_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_we,
  input  logic [CRD_W-1:0]        pix_row,
  input  logic [CRD_W-1:0]        pix_col,
  input  logic [PIX_W-1:0]        pix_data,
  input  logic                    ker_we,
  input  logic [KCRD_W-1:0]       ker_row,
  input  logic [KCRD_W-1:0]       ker_col,
  input  logic [WGT_W-1:0]        ker_data,
  input  logic                    start,
  input  logic [STR_W-1:0]        stride,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic                    res_valid,
  output logic [CRD_W-1:0]        res_row,
  output logic [CRD_W-1:0]        res_col,
  output logic signed [RES_W-1:0] res_value
);
  localparam int GN    = (IMG_N - KER_N + 1 + KER_N - 1) / KER_N;
  localparam int SLOTS = GN * GN;
  localparam int IDX_W = ($clog2(SLOTS) > 0) ? $clog2(SLOTS) : 1;
  localparam int LAST  = IMG_N - KER_N;

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [IMG_N*IMG_N*PIX_W-1:0] img_q, img_d;
  logic [KER_N*KER_N*WGT_W-1:0] ker_q, ker_d;

  always_comb begin
    img_d = img_q;
    if (pix_we && (int'(pix_row) < IMG_N) && (int'(pix_col) < IMG_N))
      img_d[(int'(pix_row) * IMG_N + int'(pix_col)) * PIX_W +: PIX_W] = pix_data;
  end

  always_comb begin
    ker_d = ker_q;
    if (ker_we && (int'(ker_row) < KER_N) && (int'(ker_col) < KER_N))
      ker_d[(int'(ker_row) * KER_N + int'(ker_col)) * WGT_W +: WGT_W] = ker_data;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      img_q <= '0;
      ker_q <= '0;
    end else begin
      if (pix_we) img_q <= img_d;
      if (ker_we) ker_q <= ker_d;
    end
  end

  logic             pos_phase, neg_phase, emit_en;
  logic [IDX_W-1:0] emit_idx;
  logic [STR_W-1:0] voff, hoff, stride_q;

  fsca_pass_seq #(
    .IMG_N(IMG_N), .KER_N(KER_N), .STR_W(STR_W), .SLOTS(SLOTS), .IDX_W(IDX_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start    (start),
    .stride   (stride),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .pos_phase(pos_phase),
    .neg_phase(neg_phase),
    .emit_en  (emit_en),
    .emit_idx (emit_idx),
    .voff     (voff),
    .hoff     (hoff),
    .stride_q (stride_q)
  );

  int spacing;
  assign spacing = KER_N + int'(stride_q) - 1;

  logic [SLOTS-1:0]        slot_ok;
  logic [CRD_W-1:0]        slot_row [SLOTS];
  logic [CRD_W-1:0]        slot_col [SLOTS];
  logic signed [RES_W-1:0] acc_q    [SLOTS];

  for (genvar ga = 0; ga < GN; ga++) begin : g_row
    for (genvar gb = 0; gb < GN; gb++) begin : g_col
      localparam int SI = ga * GN + gb;
      int               orow, ocol;
      logic [POS_W-1:0] pos_s, neg_s;

      always_comb begin
        orow = int'(voff) + ga * spacing;
        ocol = int'(hoff) + gb * spacing;
        slot_ok[SI]  = (orow <= LAST) && (ocol <= LAST);
        slot_row[SI] = slot_ok[SI] ? CRD_W'(orow) : '0;
        slot_col[SI] = slot_ok[SI] ? CRD_W'(ocol) : '0;
      end

      fsca_window_mac #(.IMG_N(IMG_N), .KER_N(KER_N), .POS_W(POS_W)) u_mac (
        .img    (img_q),
        .ker    (ker_q),
        .orow   (orow),
        .ocol   (ocol),
        .ok     (slot_ok[SI]),
        .pos_sum(pos_s),
        .neg_sum(neg_s)
      );

      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i)       acc_q[SI] <= '0;
        else if (pos_phase) acc_q[SI] <= signed'({1'b0, pos_s});
        else if (neg_phase) acc_q[SI] <= acc_q[SI] - signed'({1'b0, neg_s});
      end
    end
  end

  logic                    rv_d;
  logic [CRD_W-1:0]        rr_d, rc_d;
  logic signed [RES_W-1:0] val_d;

  always_comb begin
    rv_d  = emit_en && slot_ok[emit_idx];
    rr_d  = slot_row[emit_idx];
    rc_d  = slot_col[emit_idx];
    val_d = acc_q[emit_idx];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      res_valid <= 1'b0;
      res_row   <= '0;
      res_col   <= '0;
      res_value <= '0;
    end else begin
      res_valid <= rv_d;
      if (rv_d) begin
        res_row   <= rr_d;
        res_col   <= rc_d;
        res_value <= val_d;
      end
    end
  end

  // R4
  origin_range_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    res_valid |-> (int'(res_row) <= LAST) && (int'(res_col) <= LAST));
  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |-> !res_valid);
  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    err |-> !res_valid && !done);
  // R7
  result_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    res_valid |-> busy);
endmodule

// File: tb/fsca_conv_engine_bench.sv
module fsca_conv_engine_bench;
  localparam int M  = 6;
  localparam int D  = 3;
  localparam int CW = 3;
  localparam int KW = 2;
  localparam int SW = 3;
  localparam int RW = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_we = 1'b0, ker_we = 1'b0, start = 1'b0;
  logic [CW-1:0] pix_row = '0, pix_col = '0;
  logic [7:0]    pix_data = '0, ker_data = '0;
  logic [KW-1:0] ker_row = '0, ker_col = '0;
  logic [SW-1:0] stride = '0;
  logic busy, done, err, res_valid;
  logic [CW-1:0] res_row, res_col;
  logic signed [RW-1:0] res_value;

  always #4 clk = ~clk;

  fsca_conv_engine #(.IMG_N(M), .KER_N(D)) u_fsca_conv_engine (
    .clk(clk), .rst_n(rst_n),
    .pix_we(pix_we), .pix_row(pix_row), .pix_col(pix_col), .pix_data(pix_data),
    .ker_we(ker_we), .ker_row(ker_row), .ker_col(ker_col), .ker_data(ker_data),
    .start(start), .stride(stride),
    .busy(busy), .done(done), .err(err),
    .res_valid(res_valid), .res_row(res_row), .res_col(res_col), .res_value(res_value)
  );

  int checks = 0;
  int fails  = 0;
  int img_m [M][M];
  int ker_m [D][D];
  int exp_r [64], exp_c [64], exp_v [64];
  int got_r [64], got_c [64], got_v [64];
  int n_exp, n_got;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int win_sum(input int r, input int c);
    int s = 0;
    for (int i = 0; i < D; i++)
      for (int j = 0; j < D; j++)
        s += img_m[r+i][c+j] * ker_m[i][j];
    return s;
  endfunction

  task automatic build_exp(input int s);
    int sp = D + s - 1;
    n_exp = 0;
    for (int v = 0; v < D; v += s)
      for (int h = 0; h < D; h += s)
        for (int r = v; r <= M - D; r += sp)
          for (int c = h; c <= M - D; c += sp) begin
            exp_r[n_exp] = r;
            exp_c[n_exp] = c;
            exp_v[n_exp] = win_sum(r, c);
            n_exp++;
          end
  endtask

  task automatic load_all();
    for (int r = 0; r < M; r++)
      for (int c = 0; c < M; c++) begin
        @(negedge clk);
        pix_we = 1'b1; pix_row = CW'(r); pix_col = CW'(c); pix_data = 8'(img_m[r][c]);
      end
    @(negedge clk); pix_we = 1'b0;
    for (int r = 0; r < D; r++)
      for (int c = 0; c < D; c++) begin
        @(negedge clk);
        ker_we = 1'b1; ker_row = KW'(r); ker_col = KW'(c); ker_data = 8'(ker_m[r][c]);
      end
    @(negedge clk); ker_we = 1'b0;
  endtask

  task automatic run(input int s, input bit restart, input string req);
    bit seen_done = 1'b0;
    build_exp(s);
    n_got = 0;
    @(negedge clk);
    start = 1'b1; stride = SW'(s);
    for (int cyc = 0; cyc < 2000; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (cyc == 0) chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
      if (restart && cyc == 3) begin start = 1'b1; stride = SW'(1); end
      if (res_valid && n_got < 64) begin
        got_r[n_got] = int'(res_row);
        got_c[n_got] = int'(res_col);
        got_v[n_got] = int'(res_value);
        n_got++;
      end
      if (done) begin seen_done = 1'b1; break; end
    end
    chk(seen_done, "R7 done seen", int'(seen_done), 1);
    chk(n_got == n_exp, {req, " R5 result count"}, n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got; k++) begin
      chk(got_r[k] == exp_r[k] && got_c[k] == exp_c[k], {req, " R4 origin order"},
          got_r[k] * 100 + got_c[k], exp_r[k] * 100 + exp_c[k]);
      chk(got_v[k] == exp_v[k], {req, " R3 window sum"}, got_v[k], exp_v[k]);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7 done one cycle", int'(done), 0);
  endtask

  task automatic rand_fill();
    for (int r = 0; r < M; r++)
      for (int c = 0; c < M; c++) img_m[r][c] = int'($urandom_range(255, 0));
    for (int r = 0; r < D; r++)
      for (int c = 0; c < D; c++) ker_m[r][c] = int'($urandom_range(255, 0)) - 128;
  endtask

  task automatic err_case(input int s);
    bit quiet = 1'b1;
    @(negedge clk);
    start = 1'b1; stride = SW'(s);
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R2 err raised", int'(err), 1);
    @(negedge clk);
    chk(err == 1'b0, "R2 err one cycle", int'(err), 0);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (res_valid || done || busy) quiet = 1'b0;
    end
    chk(quiet, "R2 no run after reject", int'(quiet), 1);
  endtask

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'd7351);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !res_valid, "R1 outputs in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err && !res_valid, "R1 outputs after reset",
        int'({busy, done, err, res_valid}), 0);

    rand_fill(); load_all();
    run(1, 1'b0, "R5 stride1");
    run(2, 1'b0, "R5 stride2");
    run(3, 1'b0, "R5 stride3");

    for (int r = 0; r < M; r++) for (int c = 0; c < M; c++) img_m[r][c] = 255;
    for (int r = 0; r < D; r++) for (int c = 0; c < D; c++) ker_m[r][c] = -128;
    load_all();
    run(1, 1'b0, "R6 full negative");
    chk(n_got > 0 && got_v[0] == -293760, "R6 negative extreme", got_v[0], -293760);
    for (int r = 0; r < D; r++) for (int c = 0; c < D; c++) ker_m[r][c] = 127;
    load_all();
    run(2, 1'b0, "R6 full positive");
    chk(n_got > 0 && got_v[0] == 291465, "R6 positive extreme", got_v[0], 291465);

    err_case(4);
    err_case(0);
    err_case(7);

    rand_fill(); load_all();
    run(2, 1'b1, "R8 restart ignored");

    for (int t = 0; t < 4; t++) begin
      rand_fill(); load_all();
      run(int'($urandom_range(3, 1)), 1'b0, "R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule